// File: doc/BRIEF.md
# Speculative Serial Result Readout Port

This block is the digital serial port of a multi-sample converter. Conversion results come in from a stand-in filler over a valid/ready stream and are held in a small FIFO. A host reads them back through 16-clock serial frames on a chip-select / serial-clock / serial-in / serial-out link. An interrupt tells the host that the FIFO has reached a programmable fill level. The block does not own the tri-state pad: it drives `sdo_oe`, and the pad is high impedance whenever `sdo_oe` is low.

Once the interrupt is up, the next frame is taken to be a FIFO read. The oldest result starts to shift out as soon as chip select falls, before the command has been decoded. When the top four command bits arrive, the block decodes them. If they are not the read code, output stops at once and the FIFO is emptied. Read frames then continue one entry per frame until the FIFO is empty. A frame that ends early, or any non-read frame, ends the readout and discards whatever was not read.

The result input follows the usual stream rules. A word is taken on each system clock in which `res_valid` and `res_ready` are both high. `res_ready` is low while the FIFO is full and while a readout is in progress. The source must hold `res_valid` and `res_data` steady until the word is taken.

Top module: `spec_fifo_serial`

## Requirements
- R1: A frame opens only on a falling edge of `cs_n` while `fs` is high. A falling edge of `cs_n` with `fs` low is ignored: no output is enabled and `irq` is unchanged.
- R2: `sdo_oe` is high only while result bits are being shifted in a readout frame. Whenever `sdo_oe` is low, `sdo` is 0.
- R3: Command bits are sampled on rising `sclk` edges, most significant bit first. The command type is bits 15..12, and 4'hE is the FIFO-read code. The type is decoded after the fourth rising edge.
- R4: `irq` rises once the FIFO count reaches `thresh`; a `thresh` of 0 acts as 1. It falls when a readout frame opens.
- R5: In a readout frame, bit 15 of the oldest entry's frame appears on `sdo` as soon as the frame opens. The frame is {result[13:0], 2'b00}, and later bits change on falling `sclk` edges.
- R6: If the decoded type in a readout frame is not 4'hE, `sdo_oe` drops before the fifth bit, the readout ends and every stored entry is discarded.
- R7: A readout frame that completes 16 rising edges before `cs_n` rises removes one entry. Later frames return the following entries in arrival order until the FIFO is empty, and then the readout ends.
- R8: If `cs_n` rises before 16 rising edges in a readout frame, the readout ends and all remaining entries are discarded.
- R9: While a readout is in progress, `eoc` stays low, `irq` stays low and `res_ready` is low.
- R10: A result is accepted when `res_valid` and `res_ready` are both high. `res_ready` is low when DEPTH entries are stored. `eoc` pulses for one cycle for every accepted result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the serial link |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock |
| fs | input | 1 | Frame sync, held high for frames |
| sdi | input | 1 | Serial command input |
| sdo | output | 1 | Serial result output data |
| sdo_oe | output | 1 | Output enable for the tri-state pad |
| irq | output | 1 | Interrupt, FIFO reached threshold |
| eoc | output | 1 | One-cycle pulse per stored result |
| thresh | input | $clog2(DEPTH+1) | Interrupt fill threshold |
| res_valid | input | 1 | Result stream valid |
| res_ready | output | 1 | Result stream ready |
| res_data | input | 14 | Result word |

## Verification
The hardest case to reach is a speculative output that has already put real data on the pins and must then be cut off when a non-read command is decoded. A second hard case is a readout that ends in the middle of the stored entries. For each threshold from 1 to the full depth, the bench fills the FIFO to the threshold and reads it back frame by frame. It then forces the two abort paths with a non-read command and with a short frame. For the non-read case it checks that exactly the first four bits came out. It then refills with fresh values and confirms that none of the older values return.

// File: rtl/sfr_pkg.sv
package sfr_pkg;
  localparam int RES_W      = 14;
  localparam int FRAME_BITS = 16;
  localparam int TYPE_BITS  = 4;
  localparam logic [TYPE_BITS-1:0] CMD_FIFO_READ = 4'hE;
endpackage

// File: rtl/sfr_sync.sv
module sfr_sync #(
  parameter int N = 4,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  logic [N-1:0] meta;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= RST_VAL;
      q    <= RST_VAL;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/sfr_fifo.sv
module sfr_fifo #(
  parameter int DEPTH = 8,
  parameter int W     = 14,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH+1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [W-1:0]  wr_data,
  input  logic          rd_en,
  input  logic          flush,
  output logic [W-1:0]  head,
  output logic [CW-1:0] count,
  output logic          full
);
  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp, rp;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  assign head = mem[rp];
  assign full = (count == CW'(DEPTH));

  always_ff @(posedge clk) begin
    if (wr_en) mem[wp] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; count <= '0;
    end else if (flush) begin
      wp <= '0; rp <= '0; count <= '0;
    end else begin
      if (wr_en) wp <= bump(wp);
      if (rd_en) rp <= bump(rp);
      case ({wr_en, rd_en})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/sfr_frame.sv
module sfr_frame
  import sfr_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int CW   = $clog2(DEPTH+1),
  localparam int BW   = $clog2(FRAME_BITS+1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_fall,
  input  logic             cs_rise,
  input  logic             sclk_rise,
  input  logic             sclk_fall,
  input  logic             sdi_s,
  input  logic             fs_s,
  input  logic [RES_W-1:0] head,
  input  logic [CW-1:0]    fifo_count,
  input  logic [CW-1:0]    thresh,
  output logic             pop,
  output logic             flush,
  output logic             sdo,
  output logic             sdo_oe,
  output logic             irq,
  output logic             rd_active
);
  logic                  in_frame, decoded;
  logic [BW-1:0]         bit_cnt;
  logic [TYPE_BITS-1:0]  type_sh;
  logic [FRAME_BITS-1:0] out_sh;
  logic [CW-1:0]         thr_eff;
  logic                  start_frame, start_read, decode_now, abort, close_full, close_short;

  assign thr_eff     = (thresh == '0) ? CW'(1) : thresh;
  assign start_frame = cs_fall && fs_s && !in_frame;
  assign start_read  = start_frame && (irq || rd_active);
  assign decode_now  = in_frame && !cs_rise && !decoded && (bit_cnt == BW'(TYPE_BITS));
  assign abort       = decode_now && sdo_oe && (type_sh != CMD_FIFO_READ);
  assign close_full  = in_frame && cs_rise && rd_active && (bit_cnt == BW'(FRAME_BITS));
  assign close_short = in_frame && cs_rise && rd_active && (bit_cnt != BW'(FRAME_BITS));
  assign pop         = close_full;
  assign flush       = abort || close_short;
  assign sdo         = sdo_oe && out_sh[FRAME_BITS-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_frame <= 1'b0; decoded <= 1'b0; bit_cnt <= '0; type_sh <= '0;
      out_sh <= '0; sdo_oe <= 1'b0; irq <= 1'b0; rd_active <= 1'b0;
    end else begin
      if (start_frame) begin
        in_frame <= 1'b1;
        decoded  <= 1'b0;
        bit_cnt  <= '0;
        if (start_read) begin
          rd_active <= 1'b1;
          irq       <= 1'b0;
          sdo_oe    <= 1'b1;
          out_sh    <= {head, 2'b00};
        end
      end else if (in_frame) begin
        if (cs_rise) begin
          in_frame <= 1'b0;
          sdo_oe   <= 1'b0;
          if (close_short || (close_full && fifo_count == CW'(1))) rd_active <= 1'b0;
        end else begin
          if (sclk_rise && bit_cnt != BW'(FRAME_BITS)) begin
            bit_cnt <= bit_cnt + 1'b1;
            type_sh <= {type_sh[TYPE_BITS-2:0], sdi_s};
          end
          if (sclk_fall && sdo_oe) out_sh <= out_sh << 1;
          if (decode_now) begin
            decoded <= 1'b1;
            if (abort) begin
              sdo_oe    <= 1'b0;
              rd_active <= 1'b0;
            end
          end
        end
      end
      if (!start_read && !rd_active && fifo_count != '0 && fifo_count >= thr_eff)
        irq <= 1'b1;
    end
  end
endmodule

// File: rtl/spec_fifo_serial.sv
module spec_fifo_serial
  import sfr_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int CW   = $clog2(DEPTH+1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             sclk,
  input  logic             fs,
  input  logic             sdi,
  output logic             sdo,
  output logic             sdo_oe,
  output logic             irq,
  output logic             eoc,
  input  logic [CW-1:0]    thresh,
  input  logic             res_valid,
  output logic             res_ready,
  input  logic [RES_W-1:0] res_data
);
  logic [3:0]       sync_q;
  logic             cs_s, sclk_s, fs_s, sdi_s, cs_prev, sclk_prev;
  logic             pop, flush, full, rd_active, wr_en;
  logic [RES_W-1:0] head;
  logic [CW-1:0]    fifo_count;

  sfr_sync #(.N(4), .RST_VAL(4'b1000)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({cs_n, sclk, fs, sdi}), .q(sync_q)
  );
  assign {cs_s, sclk_s, fs_s, sdi_s} = sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_prev <= 1'b1; sclk_prev <= 1'b0; eoc <= 1'b0;
    end else begin
      cs_prev   <= cs_s;
      sclk_prev <= sclk_s;
      eoc       <= wr_en;
    end
  end

  assign res_ready = !rd_active && !full;
  assign wr_en     = res_valid && res_ready;

  sfr_fifo #(.DEPTH(DEPTH), .W(RES_W)) u_fifo (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(res_data),
    .rd_en(pop), .flush(flush), .head(head), .count(fifo_count), .full(full)
  );

  sfr_frame #(.DEPTH(DEPTH)) u_frame (
    .clk(clk), .rst_n(rst_n),
    .cs_fall(cs_prev && !cs_s), .cs_rise(!cs_prev && cs_s),
    .sclk_rise(!sclk_prev && sclk_s), .sclk_fall(sclk_prev && !sclk_s),
    .sdi_s(sdi_s), .fs_s(fs_s), .head(head), .fifo_count(fifo_count),
    .thresh(thresh), .pop(pop), .flush(flush), .sdo(sdo), .sdo_oe(sdo_oe),
    .irq(irq), .rd_active(rd_active)
  );
endmodule

// File: rtl/sfr_checker.sv
module sfr_checker #(
  parameter int DEPTH = 8,
  localparam int CW   = $clog2(DEPTH+1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sdo,
  input logic          sdo_oe,
  input logic          irq,
  input logic          eoc,
  input logic          res_ready,
  input logic          rd_active,
  input logic [CW-1:0] fifo_count
);
  // R2
  sdo_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n) !sdo_oe |-> !sdo);
  // R2
  oe_in_readout_chk: assert property (@(posedge clk) disable iff (!rst_n) sdo_oe |-> rd_active);
  // R9
  no_eoc_in_read_chk: assert property (@(posedge clk) disable iff (!rst_n) rd_active |-> (!eoc && !res_ready));
  // R4
  irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(rd_active) |-> !irq);
  // R10
  full_stall_chk: assert property (@(posedge clk) disable iff (!rst_n) (fifo_count == CW'(DEPTH)) |-> !res_ready);
  // R10
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n) fifo_count <= CW'(DEPTH));
  // R7
  readout_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(rd_active) |-> fifo_count != '0);
endmodule

bind spec_fifo_serial sfr_checker #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .sdo(sdo), .sdo_oe(sdo_oe), .irq(irq), .eoc(eoc),
  .res_ready(res_ready), .rd_active(rd_active), .fifo_count(fifo_count)
);

// File: tb/spec_fifo_serial_tb.sv
module spec_fifo_serial_tb;
  localparam int DEPTH = 8;
  localparam int CW    = $clog2(DEPTH+1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, sclk = 1'b0, fs = 1'b1, sdi = 1'b0;
  logic sdo, sdo_oe, irq, eoc, res_ready;
  logic res_valid = 1'b0;
  logic [13:0] res_data = '0;
  logic [CW-1:0] thresh = CW'(1);
  int checks = 0, fails = 0, eoc_seen = 0, accepted = 0;
  bit done = 0;

  always #4 clk = ~clk;

  spec_fifo_serial #(.DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .fs(fs), .sdi(sdi),
    .sdo(sdo), .sdo_oe(sdo_oe), .irq(irq), .eoc(eoc), .thresh(thresh),
    .res_valid(res_valid), .res_ready(res_ready), .res_data(res_data)
  );

  always @(posedge clk) if (rst_n && eoc) eoc_seen++;

  function automatic logic [13:0] val(input int t, input int i);
    return 14'((t * 1103 + i * 419 + 5) % 16384);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push(input logic [13:0] v);
    @(negedge clk);
    res_valid = 1'b1; res_data = v;
    while (!res_ready) @(negedge clk);
    @(negedge clk);
    res_valid = 1'b0;
    accepted++;
    repeat (3) @(negedge clk);
  endtask

  task automatic frame(input logic [15:0] cmd, input int nrise, input logic fsv,
                       output logic [15:0] got, output logic [15:0] oes);
    got = '0; oes = '0;
    @(negedge clk); fs = fsv;
    repeat (4) @(negedge clk); cs_n = 1'b0;
    repeat (8) @(negedge clk);
    for (int i = 0; i < nrise; i++) begin
      got[15-i] = sdo; oes[15-i] = sdo_oe;
      sdi = cmd[15-i];
      repeat (6) @(negedge clk); sclk = 1'b1;
      repeat (6) @(negedge clk); sclk = 1'b0;
      repeat (6) @(negedge clk);
    end
    cs_n = 1'b1;
    repeat (8) @(negedge clk);
    fs = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] got, oes;
    repeat (4) @(negedge clk); rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R2 reset oe", sdo_oe, 0);
    chk("R4 reset irq", irq, 0);
    chk("R10 reset ready", res_ready, 1);
    chk("R10 reset eoc", eoc, 0);

    for (int t = 1; t <= DEPTH; t++) begin
      thresh = CW'(t);
      for (int i = 0; i < t - 1; i++) push(val(t, i));
      chk("R4 below thresh", irq, 0);
      push(val(t, t - 1));
      chk("R4 at thresh", irq, 1);
      if (t == DEPTH) chk("R10 full stall", res_ready, 0);
      frame(16'hE000, 16, 1'b0, got, oes);
      chk("R1 fs low ignored oe", oes, 16'h0000);
      chk("R1 fs low irq kept", irq, 1);
      for (int i = 0; i < t; i++) begin
        frame(16'hE000 | 16'(i * 37 + t), 16, 1'b1, got, oes);
        chk("R5 result bits", got, {val(t, i), 2'b00});
        chk("R2 oe during read", oes, 16'hFFFF);
        chk("R9 irq low in read", irq, 0);
        if (i < t - 1) chk("R9 ready low in read", res_ready, 0);
      end
      chk("R7 readout ended ready", res_ready, 1);
      chk("R9 R10 eoc per result", eoc_seen, accepted);
    end

    // R6 with R3: type 4'h0 in top bits, 4'hE further down must not count as read
    thresh = CW'(3);
    for (int i = 0; i < 3; i++) push(val(20, i));
    frame(16'h0EEE, 16, 1'b1, got, oes);
    chk("R6 R3 abort oe", oes, 16'hF000);
    chk("R6 abort first bits", got, {val(20, 0)[13:10], 12'h000});
    chk("R6 abort irq", irq, 0);
    chk("R6 abort ready", res_ready, 1);
    thresh = CW'(1);
    push(val(21, 0));
    chk("R4 refill irq", irq, 1);
    frame(16'hE123, 16, 1'b1, got, oes);
    chk("R6 discarded old data", got, {val(21, 0), 2'b00});
    frame(16'hE000, 16, 1'b1, got, oes);
    chk("R6 no leftover output", oes, 16'h0000);

    // R8 short frame
    thresh = CW'(4);
    for (int i = 0; i < 4; i++) push(val(30, i));
    frame(16'hE000, 16, 1'b1, got, oes);
    chk("R7 first entry", got, {val(30, 0), 2'b00});
    frame(16'hE000, 8, 1'b1, got, oes);
    chk("R8 partial bits", got[15:8], {val(30, 1), 2'b00} >> 8);
    frame(16'hE000, 16, 1'b1, got, oes);
    chk("R8 readout over", oes, 16'h0000);
    chk("R8 ready back", res_ready, 1);
    chk("R8 irq low", irq, 0);

    // R4 threshold zero acts as one
    thresh = '0;
    push(val(40, 0));
    chk("R4 thresh zero", irq, 1);
    frame(16'hE000, 16, 1'b1, got, oes);
    chk("R5 thresh zero data", got, {val(40, 0), 2'b00});
    chk("R10 eoc total", eoc_seen, accepted);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule